// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a 1 KB data cache with one location per memory block, placed between a processor request port and a memory port that moves a whole 32-byte line per request. Each 32-bit byte address is divided into three fields. The low five bits choose a byte in the line. The next five bits choose one of 32 lines. The top 22 bits are kept as the line's tag. For every line the block stores a valid flag, a dirty flag, a tag and 256 bits of data.

A lookup is made in the same cycle as the request. On a hit, a read returns its word and a write merges its word into the line, and neither one stalls. On a miss the block raises a stall. If the victim line is valid and dirty, the block first copies it back to memory, then fetches the new line, and then finishes the request as a hit. A line that is empty, or that holds a clean line with another tag, is refilled with no copy-back.

A build parameter chooses what happens on a write miss. With write-allocate, the line is fetched and then the word is merged into it. With no-allocate, the single word goes straight to memory through the word enables, and no line is filled.

Top module: `dmCache`

## Requirements
- R1: Address bits [4:0] select the byte in a line, bits [9:5] index one of 32 lines, and bits [31:10] are the 22-bit tag. A read returns the 32-bit word selected by bits [4:2] (word k occupies line bits [32k+31:32k]).
- R2: A hit needs the indexed line to be valid and its stored tag to equal bits [31:10]. A hit finishes in the cycle it is presented, with `cpuStall` low and no memory request.
- R3: A miss on an invalid line makes exactly one line read (`memWe`=0) and no memory write.
- R4: A miss on a valid line holding another tag makes one line read. If that line is dirty, a full-line write of the victim comes first, with all eight `memWordEn` bits set and the address rebuilt from the stored tag and the index. The refill read follows.
- R5: A write hit changes only the cached line and marks it dirty. Memory is not written until that line is evicted.
- R6: With `WRITE_ALLOC`=1, a write miss fetches the line and then merges the word, so a later read of that line hits.
- R7: With `WRITE_ALLOC`=0, a write miss issues one memory write with exactly one `memWordEn` bit set (bit = address bits [4:2]) and fills no line, so a later read of that address misses.
- R8: `cpuStall` is high from the cycle a miss is detected until the request finishes, and `memReq` is high only while `cpuStall` is high.
- R9: `memReq` stays high with `memAddr` stable until `memAck` is seen. An eviction ack is followed at once by the refill read.
- R10: Reset clears every valid and dirty flag, so the first access to any line misses and a line that was dirty before reset is not written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until it finishes |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 32 | Byte address |
| cpuWdata | input | 32 | Write word |
| cpuRdata | output | 32 | Read word of the indexed line |
| cpuStall | output | 1 | Request not yet finished |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1 = write to memory, 0 = line read |
| memAddr | output | 32 | Line-aligned memory address |
| memWline | output | 256 | Line data for memory writes |
| memWordEn | output | 8 | Per-word write enables |
| memRline | input | 256 | Line data returned by memory |
| memAck | input | 1 | One-cycle completion of a memory transfer |

## Verification
The properties assume two things about the inputs. First, the processor keeps `cpuReq`, `cpuWe`, `cpuAddr` and `cpuWdata` unchanged while `cpuStall` is high. Second, memory sends a single-cycle `memAck` only while `memReq` is high. The bench meets both. It changes its request only after the edge that finishes the previous one. Its memory model acknowledges after a fixed wait and then drops the ack on the next edge. Reset is applied only while the cache is idle, so no transfer is cut off halfway.

// File: rtl/dmCachePkg.sv
package dmCachePkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_BYPASS,
    ST_BYPASS_DONE
  } cacheState_e;

  typedef struct packed {
    logic writeWord;
    logic loadLine;
    logic selVictim;
    logic selBypass;
  } ctrlStrobe_t;

endpackage

// File: rtl/dmCacheData.sv
module dmCacheData
  import dmCachePkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [ADDR_W-1:0]                cpuAddr,
  input  logic [WORD_W-1:0]                cpuWdata,
  input  ctrlStrobe_t                      strobe,
  input  logic [LINE_BYTES*8-1:0]          memRline,
  output logic                             lookupHit,
  output logic                             victimDirty,
  output logic [WORD_W-1:0]                cpuRdata,
  output logic [ADDR_W-1:0]                memAddr,
  output logic [LINE_BYTES*8-1:0]          memWline,
  output logic [LINE_BYTES*8/WORD_W-1:0]   memWordEn
);

  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WORDS  = LINE_W / WORD_W;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int BYTE_W = $clog2(WORD_W / 8);

  logic [NUM_LINES-1:0] validQ;
  logic [NUM_LINES-1:0] dirtyQ;
  logic [TAG_W-1:0]     tagQ  [NUM_LINES];
  logic [LINE_W-1:0]    dataQ [NUM_LINES];

  logic [TAG_W-1:0]  tagField;
  logic [IDX_W-1:0]  idxField;
  logic [WSEL_W-1:0] wordSel;
  logic [WORDS-1:0]  wordDec;
  logic              unusedByteBits;

  assign tagField       = cpuAddr[ADDR_W-1 -: TAG_W];
  assign idxField       = cpuAddr[OFF_W +: IDX_W];
  assign wordSel        = cpuAddr[BYTE_W +: WSEL_W];
  assign unusedByteBits = ^cpuAddr[BYTE_W-1:0];

  for (genvar g = 0; g < WORDS; g++) begin : g_wordDec
    assign wordDec[g] = (wordSel == WSEL_W'(g));
  end

  // Lookup of the indexed line
  assign lookupHit   = validQ[idxField] && (tagQ[idxField] == tagField);
  assign victimDirty = validQ[idxField] && dirtyQ[idxField];
  assign cpuRdata    = dataQ[idxField][wordSel*WORD_W +: WORD_W];

  // Memory-side muxing: victim copy-back or processor-word bypass / refill address
  always_comb begin
    if (strobe.selVictim) begin
      memAddr   = {tagQ[idxField], idxField, {OFF_W{1'b0}}};
      memWline  = dataQ[idxField];
      memWordEn = '1;
    end else begin
      memAddr   = {tagField, idxField, {OFF_W{1'b0}}};
      memWline  = {WORDS{cpuWdata}};
      memWordEn = strobe.selBypass ? wordDec : '0;
    end
  end

  // Line state flags, cleared by reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else if (strobe.loadLine) begin
      validQ[idxField] <= 1'b1;
      dirtyQ[idxField] <= 1'b0;
    end else if (strobe.writeWord) begin
      dirtyQ[idxField] <= 1'b1;
    end
  end

  // Tag and data storage, no reset
  always_ff @(posedge clk) begin
    if (strobe.loadLine) begin
      tagQ[idxField]  <= tagField;
      dataQ[idxField] <= memRline;
    end else if (strobe.writeWord) begin
      dataQ[idxField][wordSel*WORD_W +: WORD_W] <= cpuWdata;
    end
  end

endmodule

// File: rtl/dmCacheCtrl.sv
module dmCacheCtrl
  import dmCachePkg::*;
#(
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic        lookupHit,
  input  logic        victimDirty,
  input  logic        memAck,
  output logic        cpuStall,
  output logic        memReq,
  output logic        memWe,
  output ctrlStrobe_t strobe
);

  cacheState_e stateQ, stateD;
  logic        missNow;
  logic        bypassWrite;

  assign missNow     = cpuReq && !lookupHit;
  assign bypassWrite = cpuWe && !WRITE_ALLOC;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (missNow) begin
          if (bypassWrite)      stateD = ST_BYPASS;
          else if (victimDirty) stateD = ST_EVICT;
          else                  stateD = ST_FILL;
        end
      end
      ST_EVICT:       if (memAck) stateD = ST_FILL;
      ST_FILL:        if (memAck) stateD = ST_IDLE;
      ST_BYPASS:      if (memAck) stateD = ST_BYPASS_DONE;
      ST_BYPASS_DONE: stateD = ST_IDLE;
      default:        stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe           = '0;
    memReq           = 1'b0;
    memWe            = 1'b0;
    cpuStall         = 1'b1;
    unique case (stateQ)
      ST_IDLE: begin
        cpuStall         = missNow;
        strobe.writeWord = cpuReq && cpuWe && lookupHit;
      end
      ST_EVICT: begin
        memReq           = 1'b1;
        memWe            = 1'b1;
        strobe.selVictim = 1'b1;
      end
      ST_FILL: begin
        memReq          = 1'b1;
        strobe.loadLine = memAck;
      end
      ST_BYPASS: begin
        memReq           = 1'b1;
        memWe            = 1'b1;
        strobe.selBypass = 1'b1;
      end
      ST_BYPASS_DONE: cpuStall = 1'b0;
      default: cpuStall = 1'b0;
    endcase
  end

endmodule

// File: rtl/dmCache.sv
module dmCache
  import dmCachePkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int NUM_LINES   = 32,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cpuReq,
  input  logic                           cpuWe,
  input  logic [ADDR_W-1:0]              cpuAddr,
  input  logic [WORD_W-1:0]              cpuWdata,
  output logic [WORD_W-1:0]              cpuRdata,
  output logic                           cpuStall,
  output logic                           memReq,
  output logic                           memWe,
  output logic [ADDR_W-1:0]              memAddr,
  output logic [LINE_BYTES*8-1:0]        memWline,
  output logic [LINE_BYTES*8/WORD_W-1:0] memWordEn,
  input  logic [LINE_BYTES*8-1:0]        memRline,
  input  logic                           memAck
);

  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WORDS  = LINE_W / WORD_W;

  ctrlStrobe_t strobe;
  logic        lookupHit;
  logic        victimDirty;

  dmCacheCtrl #(
    .WRITE_ALLOC(WRITE_ALLOC)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuReq     (cpuReq),
    .cpuWe      (cpuWe),
    .lookupHit  (lookupHit),
    .victimDirty(victimDirty),
    .memAck     (memAck),
    .cpuStall   (cpuStall),
    .memReq     (memReq),
    .memWe      (memWe),
    .strobe     (strobe)
  );

  dmCacheData #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .LINE_BYTES(LINE_BYTES),
    .NUM_LINES (NUM_LINES)
  ) i_data (
    .clk        (clk),
    .rstN       (rstN),
    .cpuAddr    (cpuAddr),
    .cpuWdata   (cpuWdata),
    .strobe     (strobe),
    .memRline   (memRline),
    .lookupHit  (lookupHit),
    .victimDirty(victimDirty),
    .cpuRdata   (cpuRdata),
    .memAddr    (memAddr),
    .memWline   (memWline),
    .memWordEn  (memWordEn)
  );

endmodule

// File: rtl/dmCacheChk.sv
module dmCacheChk #(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuStall,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [WORDS-1:0]  memWordEn
);

  assert_reqHeld_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);

  assert_addrStable_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr));

  assert_evictThenFill_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memAck && (memWordEn == '1) |=> memReq && !memWe);

  assert_reqOnlyStalled_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> cpuStall);

  assert_idleNoStall_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReq |-> !cpuStall);

  assert_fillReleases_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe && memAck |=> !cpuStall && !memReq);

  assert_bypassOneWord_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && (memWordEn != '1) |-> $countones(memWordEn) == 1);

  assert_bypassDone_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memAck && (memWordEn != '1) |=> !memReq && !cpuStall);

endmodule

bind dmCache dmCacheChk #(.ADDR_W(ADDR_W), .WORDS(WORDS)) i_dmCacheChk (.*);

// File: tb/test_dmCache.sv
module memModel (
  input  logic         clk,
  input  logic         rstN,
  input  logic         req,
  input  logic         we,
  input  logic [31:0]  addr,
  input  logic [255:0] wline,
  input  logic [7:0]   wordEn,
  output logic [255:0] rline,
  output logic         ack
);
  logic [255:0] store [256];
  int           rdCount = 0;
  int           wrCount = 0;
  logic [7:0]   hist = '0;
  logic [1:0]   waitCnt = '0;

  initial begin
    ack = 1'b0;
    for (int i = 0; i < 256; i++)
      for (int w = 0; w < 8; w++)
        store[i][w*32 +: 32] = 32'hC000_0000 | (i << 8) | w;
  end

  assign rline = store[addr[12:5]];

  always @(posedge clk) begin
    if (!rstN) begin
      ack     <= 1'b0;
      waitCnt <= '0;
    end else if (req && !ack) begin
      if (waitCnt == 2'd2) begin
        ack     <= 1'b1;
        waitCnt <= '0;
        hist    <= {hist[6:0], we};
        if (we) begin
          wrCount <= wrCount + 1;
          for (int w = 0; w < 8; w++)
            if (wordEn[w]) store[addr[12:5]][w*32 +: 32] <= wline[w*32 +: 32];
        end else begin
          rdCount <= rdCount + 1;
        end
      end else begin
        waitCnt <= waitCnt + 2'd1;
      end
    end else begin
      ack <= 1'b0;
    end
  end
endmodule

module test_dmCache;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        sel = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;

  logic [31:0]  rdataA, rdataB, memAddrA, memAddrB;
  logic         stallA, stallB, memReqA, memReqB, memWeA, memWeB, memAckA, memAckB;
  logic [255:0] wlineA, wlineB, rlineA, rlineB;
  logic [7:0]   wenA, wenB;

  dmCache #(.WRITE_ALLOC(1'b1)) i_dmCache (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq && !sel), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(rdataA), .cpuStall(stallA), .memReq(memReqA),
    .memWe(memWeA), .memAddr(memAddrA), .memWline(wlineA), .memWordEn(wenA),
    .memRline(rlineA), .memAck(memAckA));

  dmCache #(.WRITE_ALLOC(1'b0)) i_dmCacheNoAlloc (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq && sel), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(rdataB), .cpuStall(stallB), .memReq(memReqB),
    .memWe(memWeB), .memAddr(memAddrB), .memWline(wlineB), .memWordEn(wenB),
    .memRline(rlineB), .memAck(memAckB));

  memModel i_memA (.clk(clk), .rstN(rstN), .req(memReqA), .we(memWeA), .addr(memAddrA),
                   .wline(wlineA), .wordEn(wenA), .rline(rlineA), .ack(memAckA));
  memModel i_memB (.clk(clk), .rstN(rstN), .req(memReqB), .we(memWeB), .addr(memAddrB),
                   .wline(wlineB), .wordEn(wenB), .rline(rlineB), .ack(memAckB));

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  function automatic logic [31:0] initWord(logic [31:0] a);
    int ln = int'(a[12:5]);
    int w  = int'(a[4:2]);
    return 32'hC000_0000 | (ln << 8) | w;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic s, input logic we, input logic [31:0] addr,
                      input logic [31:0] wdata, output logic [31:0] rd, output int stallCycles);
    @(negedge clk);
    sel = s; cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wdata;
    stallCycles = 0;
    #1;
    while (s ? stallB : stallA) begin
      @(negedge clk);
      #1;
      stallCycles++;
    end
    rd = s ? rdataB : rdataA;
    @(posedge clk);
    #1;
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  expRd;
    logic [3:0]  expWr;
    logic        chkOrder;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'h0000_0040, 32'h0,         4'd1, 4'd0, 1'b0}, // R3 empty line
    '{1'b0, 32'h0000_0044, 32'h0,         4'd0, 4'd0, 1'b0}, // R2 hit
    '{1'b1, 32'h0000_0048, 32'hDEAD_BEEF, 4'd0, 4'd0, 1'b0}, // R5 write hit
    '{1'b0, 32'h0000_0048, 32'h0,         4'd0, 4'd0, 1'b0}, // R5 read back
    '{1'b0, 32'h0000_0440, 32'h0,         4'd1, 4'd1, 1'b1}, // R4 dirty victim
    '{1'b0, 32'h0000_0048, 32'h0,         4'd1, 4'd0, 1'b0}, // R4 clean victim
    '{1'b1, 32'h0000_0860, 32'h1234_5678, 4'd1, 4'd0, 1'b0}, // R6 write allocate
    '{1'b0, 32'h0000_087C, 32'h0,         4'd0, 4'd0, 1'b0}, // R1 word 7
    '{1'b0, 32'h8000_0060, 32'h0,         4'd1, 4'd1, 1'b1}, // R1 tag bit 31
    '{1'b0, 32'h0000_0860, 32'h0,         4'd1, 4'd0, 1'b0}, // R4 reload
    '{1'b1, 32'h0000_03FC, 32'hCAFE_F00D, 4'd1, 4'd0, 1'b0}, // R1 index 31
    '{1'b0, 32'h0000_03E0, 32'h0,         4'd0, 4'd0, 1'b0}  // R2 hit word 0
  };

  logic [31:0] refA [2048];
  logic [31:0] rd;
  int          st, rd0, wr0;

  initial begin
    for (int i = 0; i < 2048; i++) refA[i] = initWord(32'(i) << 2);

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R10 reset stall low", 32'(stallA), 32'd0);
    check("R8 reset memReq low", 32'(memReqA | memReqB), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      rd0 = i_memA.rdCount;
      wr0 = i_memA.wrCount;
      doOp(1'b0, VECS[i].we, VECS[i].addr, VECS[i].wdata, rd, st);
      if (VECS[i].we) refA[VECS[i].addr[12:2]] = VECS[i].wdata;
      else check($sformatf("R1 R2 read data vec%0d", i), rd, refA[VECS[i].addr[12:2]]);
      check($sformatf("R3 R4 line reads vec%0d", i), 32'(i_memA.rdCount - rd0), 32'(VECS[i].expRd));
      check($sformatf("R4 R5 line writes vec%0d", i), 32'(i_memA.wrCount - wr0), 32'(VECS[i].expWr));
      if (VECS[i].chkOrder)
        check($sformatf("R4 writeback before refill vec%0d", i), 32'(i_memA.hist[1:0]), 32'd2);
      if (VECS[i].expRd == 0) check($sformatf("R2 hit without stall vec%0d", i), 32'(st), 32'd0);
      else check($sformatf("R8 stall on miss vec%0d", i), 32'(st > 0), 32'd1);
    end

    check("R4 victim data in memory", i_memA.store[2][95:64], 32'hDEAD_BEEF);
    check("R4 victim neighbour word", i_memA.store[2][127:96], initWord(32'h0000_004C));

    // R7 no-allocate write miss
    rd0 = i_memB.rdCount; wr0 = i_memB.wrCount;
    doOp(1'b1, 1'b1, 32'h0000_0104, 32'h0BAD_F00D, rd, st);
    check("R7 bypass write count", 32'(i_memB.wrCount - wr0), 32'd1);
    check("R7 bypass no fill", 32'(i_memB.rdCount - rd0), 32'd0);
    check("R7 bypass word written", i_memB.store[8][63:32], 32'h0BAD_F00D);
    check("R7 bypass neighbour kept", i_memB.store[8][31:0], initWord(32'h0000_0100));
    rd0 = i_memB.rdCount;
    doOp(1'b1, 1'b0, 32'h0000_0104, 32'h0, rd, st);
    check("R7 later read misses", 32'(i_memB.rdCount - rd0), 32'd1);
    check("R7 later read data", rd, 32'h0BAD_F00D);
    rd0 = i_memB.rdCount; wr0 = i_memB.wrCount;
    doOp(1'b1, 1'b1, 32'h0000_0100, 32'h1111_2222, rd, st);
    check("R5 no-alloc write hit traffic", 32'((i_memB.rdCount - rd0) + (i_memB.wrCount - wr0)), 32'd0);
    doOp(1'b1, 1'b0, 32'h0000_0100, 32'h0, rd, st);
    check("R5 no-alloc write hit data", rd, 32'h1111_2222);

    // R10 reset clears valid and dirty
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    rd0 = i_memA.rdCount;
    doOp(1'b0, 1'b0, 32'h0000_0040, 32'h0, rd, st);
    check("R10 valid cleared", 32'(i_memA.rdCount - rd0), 32'd1);
    rd0 = i_memA.rdCount; wr0 = i_memA.wrCount;
    doOp(1'b0, 1'b0, 32'h0000_07E0, 32'h0, rd, st);
    check("R10 dirty cleared no writeback", 32'(i_memA.wrCount - wr0), 32'd0);
    check("R10 refill after reset", 32'(i_memA.rdCount - rd0), 32'd1);
    check("R10 refill data", rd, initWord(32'h0000_07E0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule